// File: doc/BRIEF.md
# Presettable Binary Up Counter with Terminal-Count Reload

This block is a synchronous binary up counter, eight bits wide by default, with a parallel preset bus. It drives an active-low terminal-count flag that is low whenever the registered count holds all ones. A mode input routes that flag back into the load path. When the mode input is set, the counter loads its preset instead of wrapping to zero, so it divides the clock by a programmable modulus.

The operation for each clock edge follows a fixed priority. The asynchronous master reset wins over everything. The parallel load comes next, then hold, then count or reload. The terminal-count flag is decoded only from the registered count, so it can drive the active-low count enable of the next stage in a wider cascade. A board or parent that leaves the mode input unused must tie it low, which selects free-running counting.

Top module: `preset_div_counter`

## Requirements
- R1: When `mreset` is high, `count` becomes zero and `tc_n` becomes high at once, without waiting for a clock edge, and both stay that way across clock edges while `mreset` stays high, whatever the other inputs are.
- R2: With `load_n` low, a rising edge copies `preset` into `count`, whatever `cnt_en_n` and `tc_reload` are.
- R3: With `load_n` high, `cnt_en_n` low and `tc_reload` low, each rising edge adds one to `count`, and all ones wraps to zero.
- R4: With `load_n` high, `cnt_en_n` low and `tc_reload` high, the counter increments as in R3. On an edge where `count` is all ones, it loads `preset` instead of wrapping.
- R5: With `load_n` high and `cnt_en_n` high, `count` keeps its value across rising edges.
- R6: `tc_n` is low exactly when `count` is all ones, independent of `cnt_en_n` and `tc_reload`.
- R7: With `tc_reload` high, counting enabled and preset P (P below all ones), `tc_n` pulses low for one cycle every 256 − P clocks.
- R8: A parallel load takes priority over a terminal-count reload and over hold on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| mreset | input | 1 | Asynchronous master reset, active high |
| cnt_en_n | input | 1 | Count enable, active low |
| load_n | input | 1 | Parallel load enable, active low |
| tc_reload | input | 1 | Routes the terminal count into the load path when high |
| preset | input | 8 | Parallel preset value |
| count | output | 8 | Registered count |
| tc_n | output | 1 | Terminal-count flag, low at all ones |

## Verification
Two events can fall on the same edge. The first is the automatic reload at all ones, and the second is an explicit parallel load. The bench provokes this by parking the count at all ones with reload mode on and counting enabled, then pulling `load_n` low with a preset that differs from the previous one. It passes only if `count` takes the new preset and `tc_n` returns high. A second case holds the count at all ones with counting disabled and checks that `tc_n` stays low and the count does not reload.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_INC    = 2'd1,
        OP_LOAD   = 2'd2,
        OP_RELOAD = 2'd3
    } pdc_op_e;

    typedef struct packed {
        logic load_n;
        logic cnt_en_n;
        logic tc_reload;
    } pdc_ctl_t;

    // Priority: explicit load, hold, then reload at terminal or increment.
    function automatic pdc_op_e pick_op(input pdc_ctl_t c, input logic at_term);
        if (!c.load_n)
            return OP_LOAD;
        else if (c.cnt_en_n)
            return OP_HOLD;
        else if (c.tc_reload && at_term)
            return OP_RELOAD;
        else
            return OP_INC;
    endfunction

endpackage

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
    import pdc_pkg::*;
(
    input  pdc_ctl_t ctl,
    input  logic     at_term,
    output pdc_op_e  op
);
    always_comb op = pick_op(ctl, at_term);
endmodule

// File: rtl/pdc_term.sv
module pdc_term #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt,
    output logic         at_term
);
    // Build the all-ones detect as a chain of per-bit AND stages.
    logic [W:0] chain;
    assign chain[0] = 1'b1;
    for (genvar i = 0; i < W; i++) begin : g_and
        assign chain[i+1] = chain[i] & cnt[i];
    end
    assign at_term = chain[W];
endmodule

// File: rtl/pdc_reg.sv
module pdc_reg
    import pdc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         mreset,
    input  pdc_op_e      op,
    input  logic [W-1:0] preset,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] nxt;

    always_comb begin
        unique case (op)
            OP_LOAD, OP_RELOAD: nxt = preset;
            OP_INC:             nxt = cnt + ONE;
            default:            nxt = cnt;
        endcase
    end

    always_ff @(posedge clk or posedge mreset) begin
        if (mreset) cnt <= '0;
        else        cnt <= nxt;
    end

    a_r2_load_copies: assert property (@(posedge clk) disable iff (mreset)
        op == OP_LOAD |=> cnt == $past(preset));
    a_r5_hold_keeps: assert property (@(posedge clk) disable iff (mreset)
        op == OP_HOLD |=> $stable(cnt));
endmodule

// File: rtl/preset_div_counter.sv
module preset_div_counter
    import pdc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         mreset,
    input  logic         cnt_en_n,
    input  logic         load_n,
    input  logic         tc_reload,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count,
    output logic         tc_n
);
    localparam logic [W-1:0] ALL1 = '1;

    pdc_ctl_t ctl;
    pdc_op_e  op;
    logic     at_term;

    assign ctl = '{load_n: load_n, cnt_en_n: cnt_en_n, tc_reload: tc_reload};

    pdc_term #(.W(W)) u_term (.cnt(count), .at_term(at_term));
    pdc_ctrl          u_ctrl (.ctl(ctl), .at_term(at_term), .op(op));
    pdc_reg  #(.W(W)) u_reg  (.clk(clk), .mreset(mreset), .op(op),
                              .preset(preset), .cnt(count));

    assign tc_n = ~at_term;

    a_r1_reset_clears: assert property (@(posedge clk)
        mreset |-> (count == '0 && tc_n));
    a_r3_wraps_zero: assert property (@(posedge clk) disable iff (mreset)
        (load_n && !cnt_en_n && !tc_reload && count == ALL1) |=> count == '0);
    a_r4_reloads: assert property (@(posedge clk) disable iff (mreset)
        (load_n && !cnt_en_n && tc_reload && !tc_n) |=> count == $past(preset));
    a_r8_load_first: assert property (@(posedge clk) disable iff (mreset)
        (!load_n && !tc_n && tc_reload) |=> count == $past(preset));
endmodule

// File: tb/sim_preset_div_counter.sv
module sim_preset_div_counter;
    logic       clk = 1'b0;
    logic       mreset, cnt_en_n, load_n, tc_reload;
    logic [7:0] preset;
    logic [7:0] count;
    logic       tc_n;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    preset_div_counter u0 (.clk(clk), .mreset(mreset), .cnt_en_n(cnt_en_n),
        .load_n(load_n), .tc_reload(tc_reload), .preset(preset),
        .count(count), .tc_n(tc_n));

    // {load_n, cnt_en_n, tc_reload, preset, exp_count, exp_tc_n}
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {3'b010, 8'hFC, 8'hFC, 1'b1},  // R2 load
        {3'b101, 8'h00, 8'hFD, 1'b1},  // R4 count
        {3'b101, 8'h00, 8'hFE, 1'b1},
        {3'b101, 8'hF0, 8'hFF, 1'b0},  // R6 low at all ones
        {3'b101, 8'hF0, 8'hF0, 1'b1},  // R4 reload
        {3'b111, 8'h00, 8'hF0, 1'b1},  // R5 hold
        {3'b001, 8'hFE, 8'hFE, 1'b1},  // R8 load over count
        {3'b100, 8'h00, 8'hFF, 1'b0},  // R3 count
        {3'b111, 8'h33, 8'hFF, 1'b0},  // R5/R6 hold at all ones, no reload
        {3'b100, 8'h00, 8'h00, 1'b1},  // R3 wrap
        {3'b010, 8'h7F, 8'h7F, 1'b1},  // R2 load while disabled
        {3'b100, 8'h00, 8'h80, 1'b1},  // R3
        {3'b011, 8'hFF, 8'hFF, 1'b0},  // R2
        {3'b001, 8'h10, 8'h10, 1'b1}   // R8 load beats reload
    };

    task automatic check(input string req, input logic [7:0] ec, input logic et);
        checks++;
        if (count !== ec || tc_n !== et) begin
            fails++;
            $display("FAIL %s: count=%h tc_n=%b expected count=%h tc_n=%b",
                     req, count, tc_n, ec, et);
        end
    endtask

    task automatic measure(input logic [7:0] p);
        int last = -1;
        @(negedge clk);
        load_n = 1'b0; cnt_en_n = 1'b0; tc_reload = 1'b1; preset = p;
        @(negedge clk);
        load_n = 1'b1;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (!tc_n) begin
                if (last >= 0) begin
                    checks++;
                    if (n - last != 256 - int'(p)) begin
                        fails++;
                        $display("FAIL R7: period=%0d expected=%0d", n - last, 256 - int'(p));
                    end
                end
                last = n;
            end
        end
    endtask

    initial begin
        mreset = 1'b1; cnt_en_n = 1'b1; load_n = 1'b1; tc_reload = 1'b0; preset = 8'h00;
        #1;
        check("R1", 8'h00, 1'b1);
        @(negedge clk); @(negedge clk);
        mreset = 1'b0;
        foreach (VEC[i]) begin
            @(negedge clk);
            {load_n, cnt_en_n, tc_reload, preset} = VEC[i][19:9];
            @(posedge clk); #2;
            check("R2-R8 table", VEC[i][8:1], VEC[i][0]);
        end
        // R1: asynchronous clear between edges
        @(negedge clk);
        load_n = 1'b0; preset = 8'hAA;
        @(posedge clk); #1;
        mreset = 1'b1; #1;
        check("R1 async", 8'h00, 1'b1);
        @(posedge clk); #2;
        check("R1 holds over load", 8'h00, 1'b1);
        @(negedge clk); mreset = 1'b0; load_n = 1'b1;
        measure(8'hF8);
        measure(8'hFD);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #200000;
        checks++; fails++;
        $display("FAIL watchdog: run did not end, expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule